// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a 32-bit integer core. It has one signed array that multiplies 32 bits by 16 bits, and a 56-bit accumulator. The core issues one operation at a time. It sets `start` for one cycle and presents an opcode and two 32-bit source words. The unit answers with a one-cycle `done` pulse, and `result` holds the word that the operation produced.

Four multiply-accumulate forms choose their operands from halfwords or full words of the sources:
- the upper halves of both sources;
- the lower halves of both sources;
- the whole first source with the upper half of the second;
- the whole first source with the lower half of the second.

Halfword-by-halfword products are treated as fractional values. They are placed so that the binary point lines up with the accumulator.

The same array also performs a full 32x32 integer multiply over three cycles, reusing the array on two halves of the multiplier. Further single-cycle operations load the accumulator, round it to a 16-bit or 32-bit boundary, or read it out through an arithmetic right shift.

Top module: `dsp_mac`

## Requirements
- R1: After reset, `busy` and `done` are low, `result` is zero and the accumulator holds zero.
- R2: Opcode 0 multiplies the signed halfwords `a[31:16]` and `b[31:16]`. Opcode 1 multiplies the signed halfwords `a[15:0]` and `b[15:0]`. In both, the 32-bit signed product is multiplied by 2^16 and added to the accumulator.
- R3: Opcode 2 multiplies signed `a` by the signed halfword `b[31:16]`. Opcode 3 multiplies signed `a` by the signed halfword `b[15:0]`. In both, the 48-bit signed product is sign-extended and added to the accumulator with no scaling.
- R4: Every opcode except 4 raises `done` on the clock edge that follows the edge accepting it, without raising `busy`. For opcodes 0, 1, 2, 3 and 5, `result` is bits [47:16] of the new accumulator.
- R5: Accumulation wraps modulo 2^56, without saturation.
- R6: Opcode 4 returns the low 32 bits of `a*b`. `busy` is high for the two cycles after acceptance, and `done` rises on the third edge counted from the accepting edge. The accumulator is not changed.
- R7: Opcode 5 loads the accumulator with `{a[23:0], b}`.
- R8: Opcode 6 with `b[0]=0` adds 2^15 to the accumulator, clears bits [15:0] and returns bits [47:16]. With `b[0]=1` it adds 2^31, clears bits [31:0] and returns bits [47:32] sign-extended to 32 bits. The addition wraps modulo 2^56.
- R9: Opcode 7 returns the low 32 bits of the accumulator shifted arithmetically right by `b[4:0]`, and leaves the accumulator unchanged.
- R10: A `start` presented while `busy` is high is ignored. The running multiply completes with its own result, and the accumulator is untouched.
- R11: In the cycle in which a multiply asserts `done`, `busy` is already low, so a `start` in that same cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Issue strobe for one operation |
| op | input | 3 | Opcode (0-3 MAC forms, 4 multiply, 5 load, 6 round, 7 shifted read) |
| a | input | 32 | First source word |
| b | input | 32 | Second source word, also carries the round select and shift amount |
| busy | output | 1 | High while the 32x32 multiply is iterating |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Word produced by the last completed operation |

## Verification
The completion of a 32x32 multiply and the issue of the next operation can fall in the same cycle, because `busy` drops as `done` rises. The bench waits for the multiply's `done` and, on that same cycle, drives a new accumulate. It then expects the multiply result to have been visible in that cycle, the accumulate to finish one edge later, and the accumulator to hold the reference sum. A second sequence issues an accumulate while the multiply is still busy. It then reads the accumulator back through the shifted read and expects the value to be unchanged.

// File: rtl/dsp_mac_pkg.sv
`timescale 1ns/1ps
package dsp_mac_pkg;
  typedef enum logic [2:0] {
    OP_MAC_HH = 3'd0,
    OP_MAC_LL = 3'd1,
    OP_MAC_WH = 3'd2,
    OP_MAC_WL = 3'd3,
    OP_MUL32  = 3'd4,
    OP_LOAD   = 3'd5,
    OP_ROUND  = 3'd6,
    OP_SHRD   = 3'd7
  } mac_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } mul_st_e;
endpackage

// File: rtl/dsp_mac_opsel.sv
`timescale 1ns/1ps
module dsp_mac_opsel
  import dsp_mac_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int HALF_W = 16
) (
  input  mac_op_e            op,
  input  mul_st_e            st,
  input  logic [WORD_W-1:0]  a,
  input  logic [WORD_W-1:0]  b,
  input  logic [WORD_W-1:0]  a_q,
  input  logic [WORD_W-1:0]  b_q,
  output logic [WORD_W-1:0]  x,
  output logic [HALF_W-1:0]  y,
  output logic               y_sgn,
  output logic               frac
);
  localparam int EXT_W = WORD_W - HALF_W;

  always_comb begin
    x     = a;
    y     = b[HALF_W-1:0];
    y_sgn = 1'b1;
    frac  = 1'b0;
    case (st)
      ST_LO: begin
        // low multiplier half is an unsigned digit
        x     = a_q;
        y     = b_q[HALF_W-1:0];
        y_sgn = 1'b0;
      end
      ST_HI: begin
        x = a_q;
        y = b_q[WORD_W-1 -: HALF_W];
      end
      default: begin
        case (op)
          OP_MAC_HH: begin
            x    = {{EXT_W{a[WORD_W-1]}}, a[WORD_W-1 -: HALF_W]};
            y    = b[WORD_W-1 -: HALF_W];
            frac = 1'b1;
          end
          OP_MAC_LL: begin
            x    = {{EXT_W{a[HALF_W-1]}}, a[HALF_W-1:0]};
            frac = 1'b1;
          end
          OP_MAC_WH: y = b[WORD_W-1 -: HALF_W];
          default: ;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/dsp_mac_mularr.sv
`timescale 1ns/1ps
module dsp_mac_mularr #(
  parameter int WORD_W = 32,
  parameter int HALF_W = 16,
  localparam int PROD_W = WORD_W + HALF_W
) (
  input  logic [WORD_W-1:0] x,
  input  logic [HALF_W-1:0] y,
  input  logic              y_sgn,
  output logic [PROD_W-1:0] prod
);
  logic signed [PROD_W-1:0] xe;
  logic signed [PROD_W-1:0] ye;

  assign xe   = {{HALF_W{x[WORD_W-1]}}, x};
  assign ye   = {{WORD_W{y_sgn & y[HALF_W-1]}}, y};
  assign prod = xe * ye;
endmodule

// File: rtl/dsp_mac_accfn.sv
`timescale 1ns/1ps
module dsp_mac_accfn
  import dsp_mac_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int HALF_W = 16,
  parameter int ACC_W  = 56,
  localparam int PROD_W = WORD_W + HALF_W,
  localparam int SH_W   = $clog2(WORD_W),
  localparam int TOP_W  = ACC_W - WORD_W
) (
  input  mac_op_e            op,
  input  logic [ACC_W-1:0]   acc,
  input  logic [PROD_W-1:0]  prod,
  input  logic               frac,
  input  logic [TOP_W-1:0]   a_lo,
  input  logic [WORD_W-1:0]  b,
  output logic [ACC_W-1:0]   acc_nx,
  output logic [WORD_W-1:0]  res_nx,
  output logic               acc_we
);
  localparam int RES_LSB = HALF_W;

  logic [ACC_W-1:0]        addend;
  logic [ACC_W-1:0]        sum;
  logic [ACC_W-1:0]        ld;
  logic [ACC_W-HALF_W-1:0] r32_hi;
  logic [ACC_W-WORD_W-1:0] r16_hi;

  assign addend = frac
    ? {{(ACC_W-PROD_W){prod[WORD_W-1]}}, prod[WORD_W-1:0], {HALF_W{1'b0}}}
    : {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  assign sum    = acc + addend;
  assign ld     = {a_lo, b};
  // half-LSB add folded into the carry of the kept field
  assign r32_hi = acc[ACC_W-1:HALF_W] + {{(ACC_W-HALF_W-1){1'b0}}, acc[HALF_W-1]};
  assign r16_hi = acc[ACC_W-1:WORD_W] + {{(ACC_W-WORD_W-1){1'b0}}, acc[WORD_W-1]};

  always_comb begin
    acc_nx = acc;
    res_nx = sum[RES_LSB+WORD_W-1:RES_LSB];
    acc_we = 1'b0;
    case (op)
      OP_MAC_HH, OP_MAC_LL, OP_MAC_WH, OP_MAC_WL: begin
        acc_nx = sum;
        acc_we = 1'b1;
      end
      OP_LOAD: begin
        acc_nx = ld;
        res_nx = ld[RES_LSB+WORD_W-1:RES_LSB];
        acc_we = 1'b1;
      end
      OP_ROUND: begin
        acc_we = 1'b1;
        if (b[0]) begin
          acc_nx = {r16_hi, {WORD_W{1'b0}}};
          res_nx = {{(WORD_W-HALF_W){r16_hi[HALF_W-1]}}, r16_hi[HALF_W-1:0]};
        end else begin
          acc_nx = {r32_hi, {HALF_W{1'b0}}};
          res_nx = r32_hi[WORD_W-1:0];
        end
      end
      OP_SHRD: res_nx = WORD_W'($signed(acc) >>> b[SH_W-1:0]);
      default: ;
    endcase
  end
endmodule

// File: rtl/dsp_mac.sv
`timescale 1ns/1ps
module dsp_mac
  import dsp_mac_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int HALF_W = 16,
  parameter int ACC_W  = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] result
);
  localparam int PROD_W = WORD_W + HALF_W;
  localparam int TOP_W  = ACC_W - WORD_W;

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  mac_op_e           op_e;
  mul_st_e           st_q, st_d;
  logic [WORD_W-1:0] a_q, b_q, psum_q, psum_d;
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [WORD_W-1:0] res_q, res_d;
  logic              done_q, done_d;
  logic              cap_en, psum_en;

  logic [WORD_W-1:0] mx;
  logic [HALF_W-1:0] my;
  logic              my_sgn, frac;
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  fn_acc;
  logic [WORD_W-1:0] fn_res;
  logic              fn_we;

  assign op_e = mac_op_e'(op);

  dsp_mac_opsel #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_opsel (
    .op(op_e), .st(st_q), .a(a), .b(b), .a_q(a_q), .b_q(b_q),
    .x(mx), .y(my), .y_sgn(my_sgn), .frac(frac)
  );

  dsp_mac_mularr #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_arr (
    .x(mx), .y(my), .y_sgn(my_sgn), .prod(prod)
  );

  dsp_mac_accfn #(.WORD_W(WORD_W), .HALF_W(HALF_W), .ACC_W(ACC_W)) u_accfn (
    .op(op_e), .acc(acc_q), .prod(prod), .frac(frac),
    .a_lo(a[TOP_W-1:0]), .b(b),
    .acc_nx(fn_acc), .res_nx(fn_res), .acc_we(fn_we)
  );

  always_comb begin
    st_d    = st_q;
    done_d  = 1'b0;
    res_d   = res_q;
    acc_d   = acc_q;
    psum_d  = psum_q;
    cap_en  = 1'b0;
    psum_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (op_e == OP_MUL32) begin
            cap_en = 1'b1;
            st_d   = ST_LO;
          end else begin
            done_d = 1'b1;
            res_d  = fn_res;
            if (fn_we) acc_d = fn_acc;
          end
        end
      end
      ST_LO: begin
        psum_en = 1'b1;
        psum_d  = prod[WORD_W-1:0];
        st_d    = ST_HI;
      end
      default: begin
        res_d  = psum_q + {prod[HALF_W-1:0], {(WORD_W-HALF_W){1'b0}}};
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= ST_IDLE;
      acc_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      acc_q  <= acc_d;
      res_q  <= res_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      a_q <= a;
      b_q <= b;
    end
    if (psum_en) psum_q <= psum_d;
  end

  assign busy   = (st_q != ST_IDLE);
  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/dsp_mac_chk.sv
`timescale 1ns/1ps
module dsp_mac_chk #(
  parameter int ACC_W = 56
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [2:0]       op,
  input logic             busy,
  input logic             done,
  input logic [ACC_W-1:0] acc
);
  p_busy_done_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_mul_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op == 3'd4) |=> busy ##1 busy ##1 (!busy && done));

  p_single_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op != 3'd4) |=> (done && !busy));

  p_busy_keeps_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(acc));

  p_read_keeps_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op == 3'd7) |=> $stable(acc));
endmodule

bind dsp_mac dsp_mac_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .start(start), .op(op),
  .busy(busy), .done(done), .acc(acc_q)
);

// File: tb/dsp_mac_tb.sv
`timescale 1ns/1ps
module dsp_mac_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  op;
  logic [31:0] a, b;
  logic        busy, done;
  logic [31:0] result;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [55:0] macc;

  dsp_mac u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
    .busy(busy), .done(done), .result(result)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y,
                       output logic [31:0] r, output int lat);
    @(negedge clk);
    start = 1'b1; op = o; a = x; b = y;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    r = result;
  endtask

  function automatic logic [55:0] mac_add(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
    logic signed [31:0] p32;
    logic signed [47:0] p48;
    case (o)
      3'd0: begin p32 = $signed(x[31:16]) * $signed(y[31:16]); return {{8{p32[31]}}, p32, 16'h0}; end
      3'd1: begin p32 = $signed(x[15:0]) * $signed(y[15:0]);   return {{8{p32[31]}}, p32, 16'h0}; end
      3'd2: begin p48 = $signed(x) * $signed(y[31:16]);        return {{8{p48[47]}}, p48}; end
      default: begin p48 = $signed(x) * $signed(y[15:0]);      return {{8{p48[47]}}, p48}; end
    endcase
  endfunction

  task automatic read_acc(input string tag);
    logic [31:0] r;
    int lat;
    do_op(3'd7, 32'h0, 32'd0, r, lat);
    check({tag, " low"}, r, macc[31:0]);
    do_op(3'd7, 32'h0, 32'd24, r, lat);
    check({tag, " high"}, r, macc[55:24]);
  endtask

  logic [15:0] hv [8];
  logic [31:0] wv [8];

  initial begin
    logic [31:0] r, x, y;
    logic [63:0] m;
    logic [55:0] t;
    int lat;
    hv = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h1234, 16'hA5A5, 16'h0002};
    wv = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000, 32'h12345678, 32'hDEADBEEF, 32'h00010000};
    rst_n = 1'b0; start = 1'b0; op = '0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 result", result, 0);
    macc = '0;
    read_acc("R1 acc");

    // R2 R3 R4 sweeps over all four MAC forms
    for (int f = 0; f < 4; f++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          x = (f < 2) ? {hv[i], hv[7-i]} : wv[i];
          y = {hv[j], hv[(j+3)%8]};
          macc = macc + mac_add(3'(f), x, y);
          do_op(3'(f), x, y, r, lat);
          check((f < 2) ? "R2 mac result" : "R3 mac result", r, macc[47:16]);
          check("R4 latency", lat, 1);
        end
      end
      read_acc("R2 R3 acc");
    end

    // R5 wrap
    macc = 56'h7F_FFFF_FFFF_FFFF;
    do_op(3'd5, 32'h007FFFFF, 32'hFFFFFFFF, r, lat);
    check("R7 load result", r, macc[47:16]);
    do_op(3'd3, 32'h1, 32'h1, r, lat);
    macc = macc + 56'd1;
    check("R5 wrap result", r, macc[47:16]);
    read_acc("R5 wrap acc");
    macc = 56'hFF_FFFF_FFFF_FFFF;
    do_op(3'd5, 32'hFFFFFFFF, 32'hFFFFFFFF, r, lat);
    do_op(3'd3, 32'h2, 32'h1, r, lat);
    macc = 56'd1;
    read_acc("R5 wrap to one");

    // R6 multiply sweep
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        m = wv[i] * wv[(j+5)%8];
        do_op(3'd4, wv[i], wv[(j+5)%8], r, lat);
        check("R6 mul result", r, m[31:0]);
        check("R6 mul latency", lat, 3);
      end
    end
    read_acc("R6 acc untouched");

    // R7 R8 rounding
    for (int k = 0; k < 6; k++) begin
      case (k)
        0: begin x = 32'h00000012; y = 32'h3456_8000; end
        1: begin x = 32'h00000012; y = 32'h3456_7FFF; end
        2: begin x = 32'h00FFFFFF; y = 32'hFFFF_8000; end
        3: begin x = 32'h00001234; y = 32'h8000_0000; end
        4: begin x = 32'h00FFFFFF; y = 32'h7FFF_FFFF; end
        default: begin x = 32'h007FFFFF; y = 32'hFFFF_FFFF; end
      endcase
      for (int s = 0; s < 2; s++) begin
        macc = {x[23:0], y};
        do_op(3'd5, x, y, r, lat);
        check("R7 load", r, macc[47:16]);
        if (s == 0) begin
          t = macc + 56'h8000;
          macc = {t[55:16], 16'h0};
          do_op(3'd6, 32'h0, 32'h0, r, lat);
          check("R8 round32", r, t[47:16]);
        end else begin
          t = macc + 56'h8000_0000;
          macc = {t[55:32], 32'h0};
          do_op(3'd6, 32'h0, 32'h1, r, lat);
          check("R8 round16", r, {{16{t[47]}}, t[47:32]});
        end
        check("R4 round latency", lat, 1);
        read_acc("R8 acc");
      end
    end

    // R9 shifted read sweep
    macc = 56'hC3_5A5A_1234_F00F;
    do_op(3'd5, 32'h00C35A5A, 32'h1234F00F, r, lat);
    for (int s = 0; s < 32; s++) begin
      t = $signed(macc) >>> s;
      do_op(3'd7, 32'hFFFF_FF00, 32'(s), r, lat);
      check("R9 shift read", r, t[31:0]);
    end
    read_acc("R9 acc unchanged");

    // R10 start during busy is ignored
    @(negedge clk);
    start = 1'b1; op = 3'd4; a = 32'h0000_1003; b = 32'h0002_0005;
    @(negedge clk);
    start = 1'b1; op = 3'd0; a = 32'h7FFF_7FFF; b = 32'h7FFF_7FFF;
    check("R10 busy seen", busy, 1);
    @(negedge clk);
    start = 1'b0;
    check("R10 still busy", busy, 1);
    @(negedge clk);
    m = 64'h1003 * 64'h20005;
    check("R10 mul done", done, 1);
    check("R10 mul result", result, m[31:0]);
    @(negedge clk);
    check("R10 no extra done", done, 0);
    read_acc("R10 acc untouched");

    // R11 start in the done cycle of a multiply
    @(negedge clk);
    start = 1'b1; op = 3'd4; a = 32'hFFFF_FFFD; b = 32'h0000_0007;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R11 done with mul", done, 1);
    check("R11 busy low at done", busy, 0);
    check("R11 mul result", result, 32'hFFFF_FFEB);
    start = 1'b1; op = 3'd3; a = 32'h0001_0000; b = 32'h0000_0003;
    macc = macc + mac_add(3'd3, 32'h0001_0000, 32'h0000_0003);
    @(negedge clk);
    start = 1'b0;
    check("R11 mac done", done, 1);
    check("R11 mac result", result, macc[47:16]);
    read_acc("R11 acc");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule